// File: doc/BRIEF.md
# Cartridge-Aware Memory Map Decoder

This block turns each CPU bus access of an 8-bit machine with a 64 KiB address space into device selects. It looks at the 16-bit address, the read/write direction and a valid strobe. It also takes two active-low configuration lines driven by a plug-in cartridge and three banking bits held in the CPU's own output port. From these it raises exactly one select per access: main RAM, the language ROM, the operating-system ROM, the character-glyph ROM, the I/O page, one of the two cartridge ROM windows, or an "open" flag. The open flag tells the cartridge that no internal device answers and that it may claim the access.

The two cartridge lines pick one of four modes. When both lines are high, the machine runs in its standard banked layout. Pulling the first line low gives an 8 KiB or a 16 KiB cartridge layout. When the first line is high and the second is low, the block enters an open-window mode. In that mode the CPU banking bits are ignored and three large ranges have no internal owner.

Main RAM sits under every device and is handled apart from the read selects. Its strobe fires on every valid access. Its write enable fires on every write except writes to the two on-chip port registers at the bottom of memory. A write aimed at a ROM therefore lands in the RAM underneath.

The decode is combinational. A parameter either places one register stage on all outputs or leaves them combinational. The default is registered.

Top module: `memmap_decoder`

## Requirements
- R1: `ram_strobe` is high for every valid access, whatever the address, mode or direction. With `cpu_valid` low, every output is low.
- R2: In open-window mode (`cart_ext_n`=1, `cart_sel_n`=0), accesses to $1000–$7FFF, $A000–$BFFF and $C000–$CFFF raise `unmapped` and assert no internal select, for reads and for writes.
- R3: In open-window mode the banking bits have no effect. $0000–$0FFF selects RAM and $D000–$DFFF selects I/O. Reads of $8000–$9FFF select cartridge low ROM, and reads of $E000–$FFFF select cartridge high ROM.
- R4: In standard mode (both cartridge lines 1), reads of $A000–$BFFF select the language ROM only when `bank_lo` and `bank_hi` are both 1. Reads of $E000–$FFFF select the OS ROM when `bank_hi` is 1. Every other read outside $D000–$DFFF selects RAM.
- R5: Outside open-window mode, $D000–$DFFF is handled as follows:
  - When `bank_lo` and `bank_hi` are both 0, it selects RAM.
  - Otherwise, with `bank_chr`=1, it selects I/O.
  - Otherwise, with `bank_chr`=0, reads select the glyph ROM.
- R6: A write whose read target would be any ROM selects RAM instead and asserts `ram_we`. Every write to an address above $0001 asserts `ram_we`, including writes that select I/O or `unmapped`.
- R7: Writes to $0000 and $0001 never assert `ram_we`.
- R8: In 8 KiB cartridge mode (`cart_ext_n`=0, `cart_sel_n`=1), the map is standard. The one change is that reads of $8000–$9FFF select cartridge low ROM when `bank_lo` and `bank_hi` are both 1.
- R9: In 16 KiB cartridge mode (both lines 0), reads of $8000–$9FFF select cartridge low ROM when `bank_lo` and `bank_hi` are both 1. Reads of $A000–$BFFF select cartridge high ROM when `bank_hi` is 1, and RAM otherwise. The rest of the map is standard.
- R10: Exactly one of the eight selects (`sel_ram`, `sel_lang_rom`, `sel_os_rom`, `sel_glyph_rom`, `sel_io`, `sel_cart_lo`, `sel_cart_hi`, `unmapped`) is high for each valid access.
- R11: With `OUT_REG`=1, every output reflects the inputs sampled one clock earlier. All outputs are 0 while reset is held and for the two cycles in which its release is synchronised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register stage |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_rnw | input | 1 | 1 = read, 0 = write |
| cpu_valid | input | 1 | Access is valid this cycle |
| cart_ext_n | input | 1 | First cartridge configuration line, active low |
| cart_sel_n | input | 1 | Second cartridge configuration line, active low |
| bank_lo | input | 1 | CPU-port bank bit for the language ROM |
| bank_hi | input | 1 | CPU-port bank bit for the OS ROM |
| bank_chr | input | 1 | CPU-port bit choosing I/O over glyph ROM |
| ram_strobe | output | 1 | RAM access strobe |
| ram_we | output | 1 | RAM write enable |
| sel_ram | output | 1 | RAM is the read/write target |
| sel_lang_rom | output | 1 | Language ROM selected |
| sel_os_rom | output | 1 | OS ROM selected |
| sel_glyph_rom | output | 1 | Character glyph ROM selected |
| sel_io | output | 1 | I/O page selected |
| sel_cart_lo | output | 1 | Cartridge low ROM window selected |
| sel_cart_hi | output | 1 | Cartridge high ROM window selected |
| unmapped | output | 1 | No internal owner; cartridge may claim |

## Verification
With the default registered stage, every output answers the inputs one clock later. The bench drives a new access at each falling edge. It compares all ten outputs at the next falling edge against a queue entry pushed when that access was driven, so a rising edge always lies between stimulus and check.

During reset and the two synchronising cycles after release, the queue holds only idle entries, so all outputs are expected at 0. The sweep covers all 32 combinations of configuration and bank lines against chosen boundary addresses in both directions, then continues with random accesses.

// File: rtl/memmap_pkg.sv
package memmap_pkg;

  typedef enum logic [1:0] {
    MODE_STD    = 2'd0,
    MODE_CART8  = 2'd1,
    MODE_CART16 = 2'd2,
    MODE_OPEN   = 2'd3
  } mode_e;

  typedef enum logic [2:0] {
    RG_LOW  = 3'd0,
    RG_MID  = 3'd1,
    RG_CLO  = 3'd2,
    RG_AB   = 3'd3,
    RG_C    = 3'd4,
    RG_D    = 3'd5,
    RG_EF   = 3'd6
  } region_e;

  typedef enum logic [2:0] {
    DEV_RAM   = 3'd0,
    DEV_LANG  = 3'd1,
    DEV_OS    = 3'd2,
    DEV_GLYPH = 3'd3,
    DEV_IO    = 3'd4,
    DEV_CLO   = 3'd5,
    DEV_CHI   = 3'd6,
    DEV_OPEN  = 3'd7
  } dev_e;

  localparam int NUM_DEV = 8;

  function automatic logic is_rom(dev_e d);
    return (d == DEV_LANG) || (d == DEV_OS) || (d == DEV_GLYPH) ||
           (d == DEV_CLO) || (d == DEV_CHI);
  endfunction

endpackage

// File: rtl/mm_mode_decode.sv
module mm_mode_decode
  import memmap_pkg::*;
(
  input  logic  cart_ext_n,
  input  logic  cart_sel_n,
  output mode_e mode
);
  always_comb begin
    unique case ({cart_ext_n, cart_sel_n})
      2'b11:   mode = MODE_STD;
      2'b10:   mode = MODE_OPEN;
      2'b01:   mode = MODE_CART8;
      default: mode = MODE_CART16;
    endcase
  end
endmodule

// File: rtl/mm_region_decode.sv
module mm_region_decode
  import memmap_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] addr,
  output region_e           region,
  output logic              is_port
);
  localparam int NIB_LSB = ADDR_W - 4;

  logic [3:0] nib;
  assign nib     = addr[ADDR_W-1:NIB_LSB];
  assign is_port = (addr[ADDR_W-1:1] == '0);

  always_comb begin
    unique case (nib)
      4'h0:                      region = RG_LOW;
      4'h1, 4'h2, 4'h3, 4'h4,
      4'h5, 4'h6, 4'h7:          region = RG_MID;
      4'h8, 4'h9:                region = RG_CLO;
      4'hA, 4'hB:                region = RG_AB;
      4'hC:                      region = RG_C;
      4'hD:                      region = RG_D;
      default:                   region = RG_EF;
    endcase
  end
endmodule

// File: rtl/mm_dev_select.sv
module mm_dev_select
  import memmap_pkg::*;
(
  input  mode_e   mode,
  input  region_e region,
  input  logic    rnw,
  input  logic    bank_lo,
  input  logic    bank_hi,
  input  logic    bank_chr,
  output dev_e    dev
);
  dev_e rd_dev;
  logic open_md;
  logic both_lh;
  logic any_lh;

  assign open_md = (mode == MODE_OPEN);
  assign both_lh = bank_lo & bank_hi;
  assign any_lh  = bank_lo | bank_hi;

  always_comb begin
    rd_dev = DEV_RAM;
    unique case (region)
      RG_LOW: rd_dev = DEV_RAM;
      RG_MID: rd_dev = open_md ? DEV_OPEN : DEV_RAM;
      RG_CLO: begin
        if (open_md)                  rd_dev = DEV_CLO;
        else if (mode != MODE_STD)    rd_dev = both_lh ? DEV_CLO : DEV_RAM;
        else                          rd_dev = DEV_RAM;
      end
      RG_AB: begin
        if (open_md)                  rd_dev = DEV_OPEN;
        else if (mode == MODE_CART16) rd_dev = bank_hi ? DEV_CHI : DEV_RAM;
        else                          rd_dev = both_lh ? DEV_LANG : DEV_RAM;
      end
      RG_C:  rd_dev = open_md ? DEV_OPEN : DEV_RAM;
      RG_D: begin
        if (open_md)                  rd_dev = DEV_IO;
        else if (!any_lh)             rd_dev = DEV_RAM;
        else                          rd_dev = bank_chr ? DEV_IO : DEV_GLYPH;
      end
      default: begin
        if (open_md)                  rd_dev = DEV_CHI;
        else                          rd_dev = bank_hi ? DEV_OS : DEV_RAM;
      end
    endcase
  end

  // Writes never target a ROM: the RAM underneath takes them.
  always_comb begin
    if (!rnw && is_rom(rd_dev)) dev = DEV_RAM;
    else                        dev = rd_dev;
  end
endmodule

// File: rtl/mm_out_stage.sv
module mm_out_stage #(
  parameter bit OUT_REG = 1'b1,
  parameter int W       = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic         rst_core_n
);
  generate
    if (OUT_REG) begin : g_reg
      logic [1:0]   sync_q;
      logic [1:0]   sync_d;
      logic [W-1:0] out_q;
      logic [W-1:0] out_d;
      logic         out_en;

      assign sync_d = {sync_q[0], 1'b1};

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= 2'b00;
        else        sync_q <= sync_d;
      end

      assign rst_core_n = sync_q[1];
      assign out_en     = 1'b1;

      always_comb begin
        out_d = out_q;
        if (out_en) out_d = d;
      end

      always_ff @(posedge clk or negedge rst_core_n) begin
        if (!rst_core_n) out_q <= '0;
        else             out_q <= out_d;
      end

      assign q = out_q;
    end else begin : g_comb
      assign rst_core_n = rst_n;
      assign q          = d;
    end
  endgenerate
endmodule

// File: rtl/memmap_decoder.sv
module memmap_decoder
  import memmap_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter bit OUT_REG = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_rnw,
  input  logic              cpu_valid,
  input  logic              cart_ext_n,
  input  logic              cart_sel_n,
  input  logic              bank_lo,
  input  logic              bank_hi,
  input  logic              bank_chr,
  output logic              ram_strobe,
  output logic              ram_we,
  output logic              sel_ram,
  output logic              sel_lang_rom,
  output logic              sel_os_rom,
  output logic              sel_glyph_rom,
  output logic              sel_io,
  output logic              sel_cart_lo,
  output logic              sel_cart_hi,
  output logic              unmapped
);
  localparam int OUT_W   = NUM_DEV + 2;
  localparam int IDX_STB = NUM_DEV;
  localparam int IDX_WE  = NUM_DEV + 1;

  mode_e   mode;
  region_e region;
  logic    is_port;
  dev_e    dev;

  logic [OUT_W-1:0] nxt;
  logic [OUT_W-1:0] outv;
  logic             rst_core_n;

  mm_mode_decode u_mode (
    .cart_ext_n (cart_ext_n),
    .cart_sel_n (cart_sel_n),
    .mode       (mode)
  );

  mm_region_decode #(.ADDR_W(ADDR_W)) u_region (
    .addr    (cpu_addr),
    .region  (region),
    .is_port (is_port)
  );

  mm_dev_select u_sel (
    .mode     (mode),
    .region   (region),
    .rnw      (cpu_rnw),
    .bank_lo  (bank_lo),
    .bank_hi  (bank_hi),
    .bank_chr (bank_chr),
    .dev      (dev)
  );

  for (genvar i = 0; i < NUM_DEV; i++) begin : g_onehot
    assign nxt[i] = cpu_valid && (dev == dev_e'(i));
  end

  assign nxt[IDX_STB] = cpu_valid;
  assign nxt[IDX_WE]  = cpu_valid && !cpu_rnw && !is_port;

  mm_out_stage #(.OUT_REG(OUT_REG), .W(OUT_W)) u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .d          (nxt),
    .q          (outv),
    .rst_core_n (rst_core_n)
  );

  assign sel_ram       = outv[DEV_RAM];
  assign sel_lang_rom  = outv[DEV_LANG];
  assign sel_os_rom    = outv[DEV_OS];
  assign sel_glyph_rom = outv[DEV_GLYPH];
  assign sel_io        = outv[DEV_IO];
  assign sel_cart_lo   = outv[DEV_CLO];
  assign sel_cart_hi   = outv[DEV_CHI];
  assign unmapped      = outv[DEV_OPEN];
  assign ram_strobe    = outv[IDX_STB];
  assign ram_we        = outv[IDX_WE];
endmodule

// File: rtl/memmap_decoder_chk.sv
module memmap_decoder_chk #(
  parameter int ADDR_W  = 16,
  parameter bit OUT_REG = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic              cpu_rnw,
  input logic              cpu_valid,
  input logic              cart_ext_n,
  input logic              cart_sel_n,
  input logic              ram_strobe,
  input logic              ram_we,
  input logic              sel_ram,
  input logic              sel_lang_rom,
  input logic              sel_os_rom,
  input logic              sel_glyph_rom,
  input logic              sel_io,
  input logic              sel_cart_lo,
  input logic              sel_cart_hi,
  input logic              unmapped
);
  localparam int NIB_LSB = ADDR_W - 4;

  logic [ADDR_W-1:0] d_addr;
  logic              d_rnw, d_valid, d_ext_n, d_sel_n;

  generate
    if (OUT_REG) begin : g_dly
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          d_addr <= '0; d_rnw <= 1'b1; d_valid <= 1'b0;
          d_ext_n <= 1'b1; d_sel_n <= 1'b1;
        end else begin
          d_addr <= cpu_addr; d_rnw <= cpu_rnw; d_valid <= cpu_valid;
          d_ext_n <= cart_ext_n; d_sel_n <= cart_sel_n;
        end
      end
    end else begin : g_now
      assign d_addr = cpu_addr;  assign d_rnw = cpu_rnw;
      assign d_valid = cpu_valid; assign d_ext_n = cart_ext_n;
      assign d_sel_n = cart_sel_n;
    end
  endgenerate

  logic [7:0] sels;
  logic [3:0] nib;
  logic       open_md, hole, port_ad, any_rom;
  assign sels    = {unmapped, sel_cart_hi, sel_cart_lo, sel_io,
                    sel_glyph_rom, sel_os_rom, sel_lang_rom, sel_ram};
  assign nib     = d_addr[ADDR_W-1:NIB_LSB];
  assign open_md = d_ext_n && !d_sel_n;
  assign hole    = (nib >= 4'h1 && nib <= 4'h7) || nib == 4'hA ||
                   nib == 4'hB || nib == 4'hC;
  assign port_ad = (d_addr[ADDR_W-1:1] == '0);
  assign any_rom = sel_lang_rom | sel_os_rom | sel_glyph_rom |
                   sel_cart_lo | sel_cart_hi;

  a_r1_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    d_valid |-> ram_strobe);
  a_r1_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !d_valid |-> (sels == 8'h00 && !ram_we && !ram_strobe));
  a_r10_one_sel: assert property (@(posedge clk) disable iff (!rst_n)
    d_valid |-> $countones(sels) == 1);
  a_r7_port_no_we: assert property (@(posedge clk) disable iff (!rst_n)
    (d_valid && !d_rnw && port_ad) |-> !ram_we);
  a_r6_write_to_ram: assert property (@(posedge clk) disable iff (!rst_n)
    (d_valid && !d_rnw && !port_ad) |-> (ram_we && !any_rom));
  a_r2_hole_open: assert property (@(posedge clk) disable iff (!rst_n)
    (d_valid && open_md && hole) |-> (unmapped && !sel_ram));
  a_r3_cart_lo_win: assert property (@(posedge clk) disable iff (!rst_n)
    (d_valid && d_rnw && open_md && nib[3:1] == 3'b100) |-> sel_cart_lo);
endmodule

bind memmap_decoder memmap_decoder_chk #(.ADDR_W(ADDR_W), .OUT_REG(OUT_REG)) u_chk (
  .clk           (clk),
  .rst_n         (rst_core_n),
  .cpu_addr      (cpu_addr),
  .cpu_rnw       (cpu_rnw),
  .cpu_valid     (cpu_valid),
  .cart_ext_n    (cart_ext_n),
  .cart_sel_n    (cart_sel_n),
  .ram_strobe    (ram_strobe),
  .ram_we        (ram_we),
  .sel_ram       (sel_ram),
  .sel_lang_rom  (sel_lang_rom),
  .sel_os_rom    (sel_os_rom),
  .sel_glyph_rom (sel_glyph_rom),
  .sel_io        (sel_io),
  .sel_cart_lo   (sel_cart_lo),
  .sel_cart_hi   (sel_cart_hi),
  .unmapped      (unmapped)
);

// File: tb/memmap_decoder_tb.sv
module memmap_decoder_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] cpu_addr;
  logic        cpu_rnw, cpu_valid, cart_ext_n, cart_sel_n;
  logic        bank_lo, bank_hi, bank_chr;
  logic        ram_strobe, ram_we, sel_ram, sel_lang_rom, sel_os_rom;
  logic        sel_glyph_rom, sel_io, sel_cart_lo, sel_cart_hi, unmapped;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  memmap_decoder u_dut (.*);

  // Expected vector order: strobe, we, ram, lang, os, glyph, io, clo, chi, open
  typedef struct { logic [9:0] v; string tag; } exp_t;
  exp_t q[$];

  function automatic logic [9:0] ref_out(input logic [15:0] a, input logic rd,
      input logic v, input logic e, input logic s, input logic lo,
      input logic hi, input logic ch);
    int dv; // 0 ram 1 lang 2 os 3 glyph 4 io 5 clo 6 chi 7 open
    logic [9:0] r;
    int top;
    top = a / 4096;
    dv = 0;
    if (e && !s) begin
      if (top == 0) dv = 0;
      else if (top <= 7 || top == 10 || top == 11 || top == 12) dv = 7;
      else if (top == 8 || top == 9) dv = 5;
      else if (top == 13) dv = 4;
      else dv = 6;
    end else begin
      if (top == 8 || top == 9) dv = (!e && lo && hi) ? 5 : 0;
      else if (top == 10 || top == 11) begin
        if (!e && !s) dv = hi ? 6 : 0;
        else dv = (lo && hi) ? 1 : 0;
      end else if (top == 13) begin
        if (!lo && !hi) dv = 0;
        else dv = ch ? 4 : 3;
      end else if (top >= 14) dv = hi ? 2 : 0;
      else dv = 0;
    end
    if (!rd && (dv == 1 || dv == 2 || dv == 3 || dv == 5 || dv == 6)) dv = 0;
    r = '0;
    if (v) begin
      r[9] = 1'b1;
      r[8] = !rd && (a > 16'h0001);
      r[7 - dv] = 1'b1;
    end
    return r;
  endfunction

  function automatic string ref_tag(input logic [15:0] a, input logic rd,
      input logic v, input logic e, input logic s);
    int top;
    top = a / 4096;
    if (!v) return "R1";
    if (!rd && a <= 16'h0001) return "R7";
    if (e && !s && (top >= 1 && top <= 12 && top != 8 && top != 9)) return "R2";
    if (e && !s) return "R3";
    if (!rd) return "R6";
    if (!e && s) return "R8";
    if (!e && !s) return "R9";
    if (top == 13) return "R5";
    return "R4";
  endfunction

  task automatic check_outputs();
    logic [9:0] act;
    exp_t ex;
    act = {ram_strobe, ram_we, sel_ram, sel_lang_rom, sel_os_rom,
           sel_glyph_rom, sel_io, sel_cart_lo, sel_cart_hi, unmapped};
    if (q.size() > 0) ex = q.pop_front();
    else begin ex.v = '0; ex.tag = "R11"; end
    n_cmp++;
    if (act !== ex.v) begin
      n_bad++;
      $display("FAIL %s: outputs act=%b exp=%b", ex.tag, act, ex.v);
    end
    if (ex.v[9]) begin // R10 one select per valid access
      n_cmp++;
      if ($countones(act[7:0]) != 1) begin
        n_bad++;
        $display("FAIL R10: select count act=%0d exp=1", $countones(act[7:0]));
      end
    end
  endtask

  // One bus cycle: check the previous access, then drive a new one.
  task automatic step(input logic [15:0] a, input logic rd, input logic v,
      input logic [4:0] cfg);
    exp_t ex;
    @(negedge clk);
    check_outputs();
    cpu_addr = a; cpu_rnw = rd; cpu_valid = v;
    {cart_ext_n, cart_sel_n, bank_lo, bank_hi, bank_chr} = cfg;
    if (rst_n) begin
      ex.v   = ref_out(a, rd, v, cfg[4], cfg[3], cfg[2], cfg[1], cfg[0]);
      ex.tag = ref_tag(a, rd, v, cfg[4], cfg[3]);
      q.push_back(ex);
    end
  endtask

  logic [15:0] pts [16] = '{16'h0000, 16'h0001, 16'h0002, 16'h0FFF,
                            16'h1000, 16'h7FFF, 16'h8000, 16'h9FFF,
                            16'hA000, 16'hBFFF, 16'hC000, 16'hCFFF,
                            16'hD000, 16'hDFFF, 16'hE000, 16'hFFFF};

  initial begin
    rst_n = 1'b0;
    cpu_addr = 16'hA000; cpu_rnw = 1'b1; cpu_valid = 1'b1;
    {cart_ext_n, cart_sel_n, bank_lo, bank_hi, bank_chr} = 5'b11111;
    // R11: reset holds every output low even with a valid access present
    repeat (3) step(16'hA000, 1'b1, 1'b1, 5'b11111);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) step(16'h0000, 1'b1, 1'b0, 5'b11111);
    // R1..R10: full configuration sweep over boundary addresses
    for (int c = 0; c < 32; c++)
      for (int p = 0; p < 16; p++)
        for (int d = 0; d < 2; d++)
          step(pts[p], d[0], 1'b1, c[4:0]);
    // R1: idle cycles between accesses
    for (int k = 0; k < 8; k++) step(16'(k * 8191), k[0], 1'b0, 5'b10000);
    // random accesses
    for (int k = 0; k < 3000; k++)
      step(16'($urandom), 1'($urandom), ($urandom % 8) != 0, 5'($urandom));
    step(16'h0000, 1'b1, 1'b0, 5'b11111);
    step(16'h0000, 1'b1, 1'b0, 5'b11111);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: run did not finish act=hung exp=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule